// File: doc/BRIEF.md
# Low-Power Mode Control Sequencer

This block manages the clocking and sleep state of a small microcontroller. It tracks whether the system clock runs from the low-speed or the high-speed source. It drives the enable of the high-speed oscillator and holds a low-power enable bit. It raises wait and stop requests toward the rest of the chip. The CPU reaches it through a one-cycle register write port with a 2-bit select and an 8-bit data word. A wake pulse from the interrupt logic ends wait or stop.

The block enforces a fixed ordering. Before the low-power bit may be set, the clock must be on the low-speed source and the high-speed oscillator must be off. Wait mode needs the low-power bit. Stop mode is refused while the low-power bit is set. To resume, the low-power bit is cleared, the oscillator is started and allowed to settle, and only then is the high-speed clock selected. Oscillator settling is modelled by a programmable down-counter.

A request that breaks one of these rules is dropped, and a sticky violation flag records it. The flag stays set until software clears it. The asynchronous reset is released through a two-stage synchronizer.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the low-speed clock is selected and the oscillator is off. The low-power bit, wait, stop and the violation flag are all 0. The settle load value is 3.
- R2: Select 0 (bit 0 = oscillator on, bit 1 = high-speed clock) starts or stops the oscillator. A start loads the settle counter with the value N. `osc_stable` rises N cycles after the write edge (at that edge when N is 0). It is 0 whenever the oscillator is off.
- R3: A request on select 0 to move to the high-speed clock while `osc_stable` is 0 is ignored and sets the violation flag. A return to the low-speed clock is always accepted.
- R4: Starting the oscillator while the low-power bit is 1 is ignored and flags a violation. Stopping it while the high-speed clock is selected is also ignored and flags a violation. The clock selection checked is the one in force before the write.
- R5: Select 1, bit 0, writes the low-power bit. Writing 1 while the oscillator is on, or while the high-speed clock is selected, is ignored and flags a violation.
- R6: A select-1 write whose bit 0 differs from that of a select-1 write in the immediately preceding cycle is ignored and flags a violation. The comparison holds whether or not the earlier write took effect. Two consecutive writes of the same value are accepted.
- R7: Select 2, bit 0, requests wait. It sets `wait_active` only when the low-power bit is 1; otherwise it is ignored and flags a violation.
- R8: Select 2, bit 1, requests stop. It is refused with a violation while the low-power bit is 1; otherwise it sets `stop_active`.
- R9: A wake pulse during wait clears `wait_active` and the low-power bit at the same edge. A wake pulse during stop clears `stop_active`. A wake pulse at any other time changes nothing.
- R10: While wait or stop is active, register writes have no effect and flag no violation.
- R11: The violation flag is sticky. A select-1 write with bit 7 set clears it, unless a violation is raised in the same cycle.
- R12: Select 3 sets the settle load value that the next oscillator start uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 clock, 1 low-power, 2 mode, 3 settle) |
| wr_data | input | 8 | Write data |
| wake | input | 1 | Interrupt wake pulse |
| clk_sel_hs | output | 1 | 1 = system clock on high-speed source |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| osc_stable | output | 1 | Oscillator settled |
| lp_en | output | 1 | Low-power enable bit |
| wait_active | output | 1 | Wait mode in force |
| stop_active | output | 1 | Stop mode in force |
| violation | output | 1 | Sticky ordering-violation flag |

## Verification
The hardest cases to reach are the ones that depend on write history, not on state. One is the opposite-value write to the low-power bit in the very next cycle. Another is a violation clear that arrives in the same cycle as a new violation. The bench therefore drives writes back to back with no idle cycle between them. It sends one write whose bit 7 clear request lands on a write that the opposite-value rule rejects. A sweep of settle values from 0 to 5 checks the exact cycle at which `osc_stable` rises.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    SEL_CLOCK  = 2'd0,
    SEL_LPEN   = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_SETTLE = 2'd3
  } pms_sel_e;

  localparam int BIT_OSC  = 0;
  localparam int BIT_HS   = 1;
  localparam int BIT_LP   = 0;
  localparam int BIT_VCLR = 7;
  localparam int BIT_WAIT = 0;
  localparam int BIT_STOP = 1;
endpackage

// File: rtl/pms_rst_sync.sv
module pms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pms_settle_timer.sv
module pms_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_start,
  input  logic             osc_on,
  input  logic [CNT_W-1:0] load_val,
  output logic             stable
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = osc_start || (osc_on && (cnt_q != '0));
    cnt_d  = osc_start ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stable = osc_on && (cnt_q == '0);
endmodule

// File: rtl/pms_clock_ctrl.sv
module pms_clock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clk,
  input  logic req_osc,
  input  logic req_hs,
  input  logic lp_en,
  input  logic stable,
  output logic osc_en,
  output logic clk_hs,
  output logic osc_start,
  output logic viol
);
  logic osc_q, osc_d, hs_q, hs_d;
  logic osc_on_try, osc_off_try, hs_on_try, hs_off_try;
  logic osc_on_bad, osc_off_bad, hs_on_bad;

  always_comb begin
    osc_on_try  = wr_clk &&  req_osc && !osc_q;
    osc_off_try = wr_clk && !req_osc &&  osc_q;
    hs_on_try   = wr_clk &&  req_hs  && !hs_q;
    hs_off_try  = wr_clk && !req_hs  &&  hs_q;

    osc_on_bad  = osc_on_try  && lp_en;
    osc_off_bad = osc_off_try && hs_q;
    hs_on_bad   = hs_on_try   && !stable;

    osc_d = osc_q;
    if (osc_on_try  && !osc_on_bad)  osc_d = 1'b1;
    if (osc_off_try && !osc_off_bad) osc_d = 1'b0;

    hs_d = hs_q;
    if (hs_on_try && !hs_on_bad) hs_d = 1'b1;
    if (hs_off_try)              hs_d = 1'b0;

    osc_start = osc_on_try && !osc_on_bad;
    viol      = osc_on_bad || osc_off_bad || hs_on_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      hs_q  <= 1'b0;
    end else if (wr_clk) begin
      osc_q <= osc_d;
      hs_q  <= hs_d;
    end
  end

  assign osc_en = osc_q;
  assign clk_hs = hs_q;
endmodule

// File: rtl/pms_lp_guard.sv
module pms_lp_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_lp,
  input  logic lp_val,
  input  logic osc_en,
  input  logic clk_hs,
  input  logic wake_clr,
  output logic lp_en,
  output logic viol
);
  logic lp_q, lp_d;
  logic prev_wr_q, prev_val_q, prev_val_d;
  logic flip_bad, set_bad, accept;

  always_comb begin
    flip_bad   = wr_lp && prev_wr_q && (lp_val != prev_val_q);
    set_bad    = wr_lp && !flip_bad && lp_val && (osc_en || clk_hs);
    accept     = wr_lp && !flip_bad && !set_bad;
    lp_d       = wake_clr ? 1'b0 : (accept ? lp_val : lp_q);
    prev_val_d = wr_lp ? lp_val : prev_val_q;
    viol       = flip_bad || set_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q       <= 1'b0;
      prev_wr_q  <= 1'b0;
      prev_val_q <= 1'b0;
    end else begin
      lp_q       <= lp_d;
      prev_wr_q  <= wr_lp;
      prev_val_q <= prev_val_d;
    end
  end

  assign lp_en = lp_q;
endmodule

// File: rtl/pms_mode_ctrl.sv
module pms_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_mode,
  input  logic req_wait,
  input  logic req_stop,
  input  logic lp_en,
  input  logic wake,
  output logic wait_act,
  output logic stop_act,
  output logic wake_clr_lp,
  output logic viol
);
  logic wait_q, wait_d, stop_q, stop_d;
  logic wait_ok, wait_bad, stop_ok, stop_bad;

  always_comb begin
    wait_ok  = wr_mode && req_wait &&  lp_en;
    wait_bad = wr_mode && req_wait && !lp_en;
    stop_ok  = wr_mode && req_stop && !lp_en;
    stop_bad = wr_mode && req_stop &&  lp_en;

    wait_d = wait_q;
    if (wait_ok)       wait_d = 1'b1;
    if (wake && wait_q) wait_d = 1'b0;

    stop_d = stop_q;
    if (stop_ok)        stop_d = 1'b1;
    if (wake && stop_q) stop_d = 1'b0;

    wake_clr_lp = wake && wait_q;
    viol        = wait_bad || stop_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      stop_q <= stop_d;
    end
  end

  assign wait_act = wait_q;
  assign stop_act = stop_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int SETTLE_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake,
  output logic              clk_sel_hs,
  output logic              hs_osc_en,
  output logic              osc_stable,
  output logic              lp_en,
  output logic              wait_active,
  output logic              stop_active,
  output logic              violation
);
  import pms_pkg::*;

  localparam logic [CNT_W-1:0] SETTLE_INIT = CNT_W'(SETTLE_RST);

  logic rst_n_i;
  logic halted, wr_go;
  logic wr_clk, wr_lp, wr_mode, wr_settle;
  logic osc_start, wake_clr_lp;
  logic viol_clk, viol_lp, viol_mode, viol_any, viol_clr;
  logic viol_q, viol_d;
  logic [CNT_W-1:0] settle_q;
  pms_sel_e sel;

  pms_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    sel       = pms_sel_e'(wr_sel);
    halted    = wait_active || stop_active;
    wr_go     = wr_en && !halted;
    wr_clk    = wr_go && (sel == SEL_CLOCK);
    wr_lp     = wr_go && (sel == SEL_LPEN);
    wr_mode   = wr_go && (sel == SEL_MODE);
    wr_settle = wr_go && (sel == SEL_SETTLE);
    viol_any  = viol_clk || viol_lp || viol_mode;
    viol_clr  = wr_lp && wr_data[BIT_VCLR];
    viol_d    = viol_any ? 1'b1 : (viol_clr ? 1'b0 : viol_q);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       settle_q <= SETTLE_INIT;
    else if (wr_settle) settle_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) viol_q <= 1'b0;
    else          viol_q <= viol_d;
  end

  pms_clock_ctrl u_clk (
    .clk(clk), .rst_n(rst_n_i), .wr_clk(wr_clk),
    .req_osc(wr_data[BIT_OSC]), .req_hs(wr_data[BIT_HS]),
    .lp_en(lp_en), .stable(osc_stable),
    .osc_en(hs_osc_en), .clk_hs(clk_sel_hs),
    .osc_start(osc_start), .viol(viol_clk)
  );

  pms_settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n_i), .osc_start(osc_start),
    .osc_on(hs_osc_en), .load_val(settle_q), .stable(osc_stable)
  );

  pms_lp_guard u_lp (
    .clk(clk), .rst_n(rst_n_i), .wr_lp(wr_lp), .lp_val(wr_data[BIT_LP]),
    .osc_en(hs_osc_en), .clk_hs(clk_sel_hs), .wake_clr(wake_clr_lp),
    .lp_en(lp_en), .viol(viol_lp)
  );

  pms_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n_i), .wr_mode(wr_mode),
    .req_wait(wr_data[BIT_WAIT]), .req_stop(wr_data[BIT_STOP]),
    .lp_en(lp_en), .wake(wake),
    .wait_act(wait_active), .stop_act(stop_active),
    .wake_clr_lp(wake_clr_lp), .viol(viol_mode)
  );

  assign violation = viol_q;
endmodule

// File: rtl/pwr_mode_seq_checker.sv
module pwr_mode_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       wake,
  input logic       clk_sel_hs,
  input logic       hs_osc_en,
  input logic       osc_stable,
  input logic       lp_en,
  input logic       wait_active,
  input logic       stop_active,
  input logic       violation
);
  a_r2_stable_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stable |-> hs_osc_en);

  a_r3_hs_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_hs) |-> $past(osc_stable));

  a_r4_no_start_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_osc_en) |-> !$past(lp_en));

  a_r5_lp_on_low_speed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_en) |-> (!clk_sel_hs && !hs_osc_en));

  a_r7_wait_implies_lp: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> lp_en);

  a_r8_stop_excludes_lp: assert property (@(posedge clk) disable iff (!rst_n)
    stop_active |-> !lp_en);

  a_r9_wake_leaves_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && wait_active) |=> (!wait_active && !lp_en));

  a_r10_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ((wait_active || stop_active) && !wake) |=>
      ($stable(hs_osc_en) && $stable(clk_sel_hs) && $stable(lp_en) && $stable(violation)));

  a_r11_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(violation) |-> $past(wr_en && (wr_sel == 2'd1) && wr_data[7]));
endmodule

bind pwr_mode_seq pwr_mode_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wake(wake), .clk_sel_hs(clk_sel_hs), .hs_osc_en(hs_osc_en),
  .osc_stable(osc_stable), .lp_en(lp_en), .wait_active(wait_active),
  .stop_active(stop_active), .violation(violation)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  logic       clk, rst_n, wr_en, wake;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       clk_sel_hs, hs_osc_en, osc_stable, lp_en;
  logic       wait_active, stop_active, violation;
  int checks, errors;
  bit done;

  pwr_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wake(wake), .clk_sel_hs(clk_sel_hs), .hs_osc_en(hs_osc_en),
    .osc_stable(osc_stable), .lp_en(lp_en), .wait_active(wait_active),
    .stop_active(stop_active), .violation(violation)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; wake = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 clk_sel_hs", clk_sel_hs, 0);
    chk("R1 hs_osc_en", hs_osc_en, 0);
    chk("R1 lp_en", lp_en, 0);
    chk("R1 wait/stop", {wait_active, stop_active}, 0);
    chk("R1 violation", violation, 0);
    // R1 default settle value 3
    put(2'd0, 8'h01); idle();
    repeat (2) @(negedge clk);
    chk("R1 settle=3 not yet", osc_stable, 0);
    @(negedge clk);
    chk("R1 settle=3 stable", osc_stable, 1);
    put(2'd0, 8'h00); idle();

    // R2/R12 settle sweep
    for (int n = 0; n <= 5; n++) begin
      put(2'd3, 8'(n));
      put(2'd0, 8'h01);
      idle();
      chk($sformatf("R2 R12 n=%0d k=0", n), osc_stable, (n == 0) ? 1 : 0);
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        chk($sformatf("R2 n=%0d k=%0d", n, k), osc_stable, (k >= n) ? 1 : 0);
      end
      put(2'd0, 8'h00); idle();
      chk("R2 off clears stable", {hs_osc_en, osc_stable}, 0);
    end
    chk("R2 no violation", violation, 0);

    // R3 high-speed request before stable
    put(2'd3, 8'd4);
    put(2'd0, 8'h03); idle();
    chk("R3 hs rejected", clk_sel_hs, 0);
    chk("R3 osc accepted", hs_osc_en, 1);
    chk("R3 violation", violation, 1);
    put(2'd1, 8'h80); idle();
    chk("R11 cleared", violation, 0);
    repeat (5) @(negedge clk);
    put(2'd0, 8'h03); idle();
    chk("R3 hs accepted", clk_sel_hs, 1);
    chk("R3 no violation", violation, 0);

    // R4 osc stop while hs selected
    put(2'd0, 8'h02); idle();
    chk("R4 osc kept", hs_osc_en, 1);
    chk("R4 violation", violation, 1);
    put(2'd1, 8'h80); idle();

    // R5 lp set while hs selected; R11 set wins over clear
    put(2'd1, 8'h01);
    put(2'd1, 8'h80);
    idle();
    chk("R5 lp rejected", lp_en, 0);
    chk("R11 set wins", violation, 1);
    put(2'd1, 8'h80); idle();
    chk("R11 cleared again", violation, 0);
    put(2'd0, 8'h01); idle();
    chk("R3 return low speed", clk_sel_hs, 0);
    put(2'd1, 8'h01); idle();
    chk("R5 lp rejected osc on", {lp_en, violation}, 1);
    put(2'd1, 8'h80); idle();
    put(2'd0, 8'h00); idle();
    put(2'd1, 8'h01); idle();
    chk("R5 lp accepted", {lp_en, violation}, 2);

    // R4 osc start with lp set
    put(2'd0, 8'h01); idle();
    chk("R4 start rejected", {hs_osc_en, violation}, 1);
    put(2'd1, 8'h81); idle();
    chk("R11 clear keeps lp", {lp_en, violation}, 2);

    // R6 back-to-back writes
    put(2'd1, 8'h01);
    put(2'd1, 8'h00);
    idle();
    chk("R6 1->0 rejected", {lp_en, violation}, 3);
    put(2'd1, 8'h81); idle();
    put(2'd1, 8'h00);
    put(2'd1, 8'h00);
    idle();
    chk("R6 same value ok", {lp_en, violation}, 0);
    put(2'd1, 8'h00);
    put(2'd1, 8'h01);
    idle();
    chk("R6 0->1 rejected", {lp_en, violation}, 1);
    put(2'd1, 8'h80); idle();
    put(2'd1, 8'h01); idle();
    chk("R6 spaced write ok", {lp_en, violation}, 2);

    // R8 stop refused with lp
    put(2'd2, 8'h02); idle();
    chk("R8 stop refused", {stop_active, violation}, 1);
    put(2'd1, 8'h81); idle();

    // R7 wait, R10 writes blocked, R9 wake
    put(2'd2, 8'h01); idle();
    chk("R7 wait entered", {wait_active, violation}, 2);
    put(2'd0, 8'h01); idle();
    chk("R10 clock write ignored", {hs_osc_en, violation}, 0);
    put(2'd1, 8'h00); idle();
    chk("R10 lp write ignored", {lp_en, violation}, 2);
    pulse_wake();
    chk("R9 wake clears wait+lp", {wait_active, lp_en}, 0);

    // R7 wait without lp
    put(2'd2, 8'h01); idle();
    chk("R7 wait refused", {wait_active, violation}, 1);
    put(2'd1, 8'h80); idle();

    // R8 stop accepted, R10, R9
    put(2'd2, 8'h02); idle();
    chk("R8 stop entered", {stop_active, violation}, 2);
    put(2'd1, 8'h01); idle();
    chk("R10 lp write ignored in stop", lp_en, 0);
    pulse_wake();
    chk("R9 wake clears stop", stop_active, 0);
    put(2'd1, 8'h01); idle();
    pulse_wake();
    chk("R9 idle wake no effect", {lp_en, wait_active, stop_active, violation}, 8);

    // resume sequence
    put(2'd1, 8'h00); idle();
    put(2'd3, 8'd2);
    put(2'd0, 8'h01); idle();
    repeat (2) @(negedge clk);
    put(2'd0, 8'h03); idle();
    chk("R3 resume reaches hs", {clk_sel_hs, violation}, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule